// File: doc/BRIEF.md
# Grouped BFloat16 Vector Multiply Engine

This engine multiplies BFloat16 vectors held in its own 32-entry vector register file. One command names a destination group and two source groups. Each group holds two or four consecutive registers, and its base is given by a short selector field. For every register in the group, the engine multiplies each 16-bit lane of the first source by the same lane of the second source. Predication does not apply, so every lane of every destination register is written.

Execution runs in two phases. In the read phase the engine fetches one pair of source registers per cycle and stores the full product vector in an internal staging buffer. In the write phase it copies one staged vector per cycle into the destination registers, and then it pulses `done`. No destination register changes until every source register has been read. Because of this, a destination group may overlap either source group and the result is still the product of the original values.

A host port loads the register file and reads it back. The read side is combinational. The write side is accepted only while the engine is idle. Command and host pins are plain level/pulse controls with no handshake: a command is taken when `start` is high and `busy` is low. A `start` seen while `busy` is high is dropped, and the host must wait for `busy` to fall before it issues another command.

Top module: `bf16_group_mul`

## Requirements
- R1: When `grp4`=0, the base register is selector×2 and the group covers base and base+1. When `grp4`=1, the base register is (selector bits 2..0)×4 and the group covers base to base+3, and selector bit 3 is ignored.
- R2: Lane e (bits 16e+15 down to 16e) of destination register d+r equals the BF16 product of lane e of register a+r and lane e of register b+r. Every lane is written, and registers outside the destination group keep their values.
- R3: The exact 16-bit significand product is rounded to 7 fraction bits, to nearest with ties to even.
- R4: A result whose exponent reaches 255 after rounding becomes infinity with the product's sign. Infinity times a finite non-zero value also gives signed infinity (0x7F80 or 0xFF80).
- R5: A NaN operand, or infinity times zero, gives 0x7FC0.
- R6: An operand with exponent field 0 is treated as zero. A result whose biased exponent is 0 or less after rounding becomes zero. In both cases the sign is kept.
- R7: All source registers are read before any destination register is written, so overlapping groups give products of the pre-command values.
- R8: After an accepted `start`, `busy` is high for 2N+1 cycles (N = group size). `done` is high only in the last of those cycles.
- R9: A `start` while `busy` is high is ignored.
- R10: With `feat_en` low, an idle `start` raises `undef` for exactly one cycle. In that case `busy` stays low and the register file is unchanged.
- R11: `host_rdata` always shows the register selected by `host_ridx`. A host write while idle updates that register on the next edge, and a host write while busy is ignored.
- R12: Reset clears every register, and clears `busy`, `done` and `undef`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feat_en | input | 1 | Enables execution. When low, a command raises `undef` instead |
| start | input | 1 | Command pulse, taken when idle |
| grp4 | input | 1 | Group size select: 0 = two registers, 1 = four registers |
| dst_sel | input | 4 | Destination group selector |
| srca_sel | input | 4 | First source group selector |
| srcb_sel | input | 4 | Second source group selector |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| undef | output | 1 | One-cycle pulse for a command refused because `feat_en` is low |
| host_we | input | 1 | Host register write strobe |
| host_widx | input | 5 | Host write register index |
| host_wdata | input | VL | Host write data |
| host_ridx | input | 5 | Host read register index |
| host_rdata | output | VL | Contents of the selected register |

## Verification
A fault in the sequencing counter or the state register shows up at `busy` or `done` within one cycle of the command length being wrong. A wrong base expansion or a writeback that happens too early shows up as mismatched contents when the register file is read back after the command, including registers outside the destination group. Errors in rounding, overflow, NaN or flush handling show up in specific lanes that the bench loads with boundary operands. The reference model tracks the expected status every cycle and the expected register file after each command.

// File: rtl/bf16_grp_pkg.sv
package bf16_grp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} grp_state_e;
  localparam logic [15:0] BF16_QNAN = 16'h7FC0;
endpackage

// File: rtl/bf16_mul_lane.sv
module bf16_mul_lane
  import bf16_grp_pkg::*;
(
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic [15:0] p_o
);
  logic [7:0]  ea, eb;
  logic [6:0]  fa, fb;
  logic        sgn, a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  logic [15:0] prod, norm;
  logic [6:0]  frac;
  logic        grd, stk, up;
  logic [7:0]  rnd;
  logic [9:0]  ebias, esum, efin;

  always_comb begin
    ea     = a_i[14:7];
    eb     = b_i[14:7];
    fa     = a_i[6:0];
    fb     = b_i[6:0];
    sgn    = a_i[15] ^ b_i[15];
    a_zero = (ea == 8'h00);
    b_zero = (eb == 8'h00);
    a_inf  = (ea == 8'hFF) && (fa == 7'h00);
    b_inf  = (eb == 8'hFF) && (fb == 7'h00);
    a_nan  = (ea == 8'hFF) && (fa != 7'h00);
    b_nan  = (eb == 8'hFF) && (fb != 7'h00);
    prod   = 16'({1'b1, fa}) * 16'({1'b1, fb});
    norm   = prod[15] ? prod : {prod[14:0], 1'b0};
    frac   = norm[14:8];
    grd    = norm[7];
    stk    = |norm[6:0];
    up     = grd & (stk | frac[0]);
    rnd    = {1'b0, frac} + 8'(up);
    // biased sum carries an extra +127; result exponent = esum - 127
    ebias  = 10'(ea) + 10'(eb) + 10'(prod[15]);
    esum   = ebias + 10'(rnd[7]);
    efin   = esum - 10'd127;
    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
      p_o = BF16_QNAN;
    else if (a_inf || b_inf)
      p_o = {sgn, 8'hFF, 7'h00};
    else if (a_zero || b_zero)
      p_o = {sgn, 15'h0000};
    else if (esum >= 10'd382)
      p_o = {sgn, 8'hFF, 7'h00};
    else if (esum <= 10'd127)
      p_o = {sgn, 15'h0000};
    else
      p_o = {sgn, efin[7:0], rnd[6:0]};
  end
endmodule

// File: rtl/bf16_vec_mul.sv
module bf16_vec_mul #(
  parameter int VL = 128,
  localparam int LANES = VL / 16
) (
  input  logic [VL-1:0] a_i,
  input  logic [VL-1:0] b_i,
  output logic [VL-1:0] p_o
);
  for (genvar e = 0; e < LANES; e++) begin : g_lane
    bf16_mul_lane u_lane (
      .a_i (a_i[16*e +: 16]),
      .b_i (b_i[16*e +: 16]),
      .p_o (p_o[16*e +: 16])
    );
  end
endmodule

// File: rtl/bf16_grp_ctrl.sv
module bf16_grp_ctrl
  import bf16_grp_pkg::*;
#(
  parameter int IDXW = 5,
  localparam int FW = IDXW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            feat_en_i,
  input  logic            grp4_i,
  input  logic [FW-1:0]   dst_sel_i,
  input  logic [FW-1:0]   srca_sel_i,
  input  logic [FW-1:0]   srcb_sel_i,
  output grp_state_e      state_o,
  output logic [1:0]      cnt_o,
  output logic [IDXW-1:0] rd_a_idx_o,
  output logic [IDXW-1:0] rd_b_idx_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic            buf_we_o,
  output logic            rf_we_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            undef_o
);
  grp_state_e      state_q;
  logic [1:0]      cnt_q;
  logic            grp4_q, undef_q, accept, last;
  logic [IDXW-1:0] base_d_q, base_a_q, base_b_q;

  function automatic logic [IDXW-1:0] expand(input logic [FW-1:0] sel, input logic four);
    return four ? {sel[FW-2:0], 2'b00} : {sel, 1'b0};
  endfunction

  assign accept = (state_q == ST_IDLE) && start_i && feat_en_i;
  assign last   = (cnt_q == (grp4_q ? 2'd3 : 2'd1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      grp4_q   <= 1'b0;
      undef_q  <= 1'b0;
      base_d_q <= '0;
      base_a_q <= '0;
      base_b_q <= '0;
    end else begin
      undef_q <= (state_q == ST_IDLE) && start_i && !feat_en_i;
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_READ;
          cnt_q    <= '0;
          grp4_q   <= grp4_i;
          base_d_q <= expand(dst_sel_i, grp4_i);
          base_a_q <= expand(srca_sel_i, grp4_i);
          base_b_q <= expand(srcb_sel_i, grp4_i);
        end
        ST_READ: begin
          cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
          if (last) state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
          if (last) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o    = state_q;
  assign cnt_o      = cnt_q;
  assign rd_a_idx_o = base_a_q + IDXW'(cnt_q);
  assign rd_b_idx_o = base_b_q + IDXW'(cnt_q);
  assign wr_idx_o   = base_d_q + IDXW'(cnt_q);
  assign buf_we_o   = (state_q == ST_READ);
  assign rf_we_o    = (state_q == ST_WRITE);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign undef_o    = undef_q;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ || state_q == ST_WRITE) |=> busy_o);
  assert_undef_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> !busy_o);
  assert_pair_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !grp4_q) |-> (cnt_q <= 2'd1));
  assert_read_before_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && cnt_q == 2'd0) |-> $past(state_q) == ST_READ);
endmodule

// File: rtl/bf16_group_mul.sv
module bf16_group_mul
  import bf16_grp_pkg::*;
#(
  parameter int VL   = 128,
  parameter int NREG = 32,
  localparam int IDXW = $clog2(NREG),
  localparam int FW   = IDXW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            feat_en,
  input  logic            start,
  input  logic            grp4,
  input  logic [FW-1:0]   dst_sel,
  input  logic [FW-1:0]   srca_sel,
  input  logic [FW-1:0]   srcb_sel,
  output logic            busy,
  output logic            done,
  output logic            undef,
  input  logic            host_we,
  input  logic [IDXW-1:0] host_widx,
  input  logic [VL-1:0]   host_wdata,
  input  logic [IDXW-1:0] host_ridx,
  output logic [VL-1:0]   host_rdata
);
  grp_state_e              state;
  logic [1:0]              cnt;
  logic [IDXW-1:0]         rd_a_idx, rd_b_idx, wr_idx;
  logic                    buf_we, rf_we;
  logic [NREG-1:0][VL-1:0] rf_q;
  logic [3:0][VL-1:0]      stage_q;
  logic [VL-1:0]           src_a, src_b, prod_vec;

  bf16_grp_ctrl #(.IDXW(IDXW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .feat_en_i  (feat_en),
    .grp4_i     (grp4),
    .dst_sel_i  (dst_sel),
    .srca_sel_i (srca_sel),
    .srcb_sel_i (srcb_sel),
    .state_o    (state),
    .cnt_o      (cnt),
    .rd_a_idx_o (rd_a_idx),
    .rd_b_idx_o (rd_b_idx),
    .wr_idx_o   (wr_idx),
    .buf_we_o   (buf_we),
    .rf_we_o    (rf_we),
    .busy_o     (busy),
    .done_o     (done),
    .undef_o    (undef)
  );

  assign src_a = rf_q[rd_a_idx];
  assign src_b = rf_q[rd_b_idx];

  bf16_vec_mul #(.VL(VL)) u_mul (
    .a_i (src_a),
    .b_i (src_b),
    .p_o (prod_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else if (buf_we) stage_q[cnt] <= prod_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rf_q <= '0;
    else if (rf_we) rf_q[wr_idx] <= stage_q[cnt];
    else if (!busy && host_we) rf_q[host_widx] <= host_wdata;
  end

  assign host_rdata = rf_q[host_ridx];

  assert_host_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rf_we) |=> $stable(rf_q));
  assert_nan_lane0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && src_a[14:7] == 8'hFF && src_a[6:0] != 7'h00)
      |-> prod_vec[15:0] == BF16_QNAN);
  assert_undef_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (undef && !$past(host_we)) |-> $stable(rf_q));
endmodule

// File: tb/bf16_group_mul_test.sv
`timescale 1ns/1ps
module bf16_group_mul_test;
  localparam int VL = 128;
  localparam int LANES = VL / 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic feat_en = 1'b1, start = 1'b0, grp4 = 1'b0;
  logic [3:0] dst_sel = '0, srca_sel = '0, srcb_sel = '0;
  logic busy, done, undef;
  logic host_we = 1'b0;
  logic [4:0] host_widx = '0, host_ridx = '0;
  logic [VL-1:0] host_wdata = '0, host_rdata;

  int compared = 0, mismatched = 0, cyc = 0;
  logic [VL-1:0] mrf [32];
  int m_left = 0;
  bit m_undef = 0;

  always #2 clk = ~clk;

  bf16_group_mul uut (
    .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .start(start), .grp4(grp4),
    .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
    .busy(busy), .done(done), .undef(undef),
    .host_we(host_we), .host_widx(host_widx), .host_wdata(host_wdata),
    .host_ridx(host_ridx), .host_rdata(host_rdata)
  );

  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    int ea = int'(a[14:7]), eb = int'(b[14:7]);
    int fa = int'(a[6:0]), fb = int'(b[6:0]);
    logic s = a[15] ^ b[15];
    real va, vb, pr;
    logic [63:0] bits;
    int de, be, top;
    bit g, st;
    if ((ea == 255 && fa != 0) || (eb == 255 && fb != 0)) return 16'h7FC0;
    if ((ea == 255 && eb == 0) || (eb == 255 && ea == 0)) return 16'h7FC0;
    if (ea == 255 || eb == 255) return {s, 8'hFF, 7'h00};
    if (ea == 0 || eb == 0) return {s, 15'h0000};
    va = (128.0 + fa) * (2.0 ** (ea - 134));
    vb = (128.0 + fb) * (2.0 ** (eb - 134));
    pr = va * vb;
    bits = $realtobits(pr);
    de = int'(bits[62:52]) - 1023;
    top = int'(bits[51:45]);
    g = bits[44];
    st = |bits[43:0];
    if (g && (st || top[0])) top++;
    if (top == 128) begin top = 0; de++; end
    be = de + 127;
    if (be >= 255) return {s, 8'hFF, 7'h00};
    if (be <= 0) return {s, 15'h0000};
    return {s, be[7:0], top[6:0]};
  endfunction

  function automatic int base_of(input logic [3:0] sel, input bit four);
    return four ? int'(sel[2:0]) * 4 : int'(sel) * 2;
  endfunction

  // behavioural model, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_undef = 0;
      for (int i = 0; i < 32; i++) mrf[i] = '0;
    end else begin
      bit idle;
      idle = (m_left == 0);
      m_undef = idle && start && !feat_en;
      if (m_left > 0) m_left--;
      if (idle && host_we) mrf[host_widx] = host_wdata;
      if (idle && start && feat_en) begin
        logic [VL-1:0] tmp [4];
        int n, d, a, b;
        n = grp4 ? 4 : 2;
        d = base_of(dst_sel, grp4);
        a = base_of(srca_sel, grp4);
        b = base_of(srcb_sel, grp4);
        for (int r = 0; r < n; r++)
          for (int e = 0; e < LANES; e++)
            tmp[r][16*e +: 16] = ref_mul(mrf[a+r][16*e +: 16], mrf[b+r][16*e +: 16]);
        for (int r = 0; r < n; r++) mrf[d+r] = tmp[r];
        m_left = 2 * n + 1;
      end
    end
  end

  // status comparison every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      compared += 3;
      if (busy !== (m_left > 0)) begin
        mismatched++;
        $display("FAIL R9 busy: actual %b expected %b", busy, m_left > 0);
      end
      if (done !== (m_left == 1)) begin
        mismatched++;
        $display("FAIL R8 done: actual %b expected %b", done, m_left == 1);
      end
      if (undef !== m_undef) begin
        mismatched++;
        $display("FAIL R10 undef: actual %b expected %b", undef, m_undef);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic host_write(input int idx, input logic [VL-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_widx = 5'(idx); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic launch(input bit four, input logic [3:0] d, input logic [3:0] a,
                        input logic [3:0] b, input bit fe);
    @(negedge clk);
    start = 1'b1; grp4 = four; dst_sel = d; srca_sel = a; srcb_sel = b; feat_en = fe;
    @(negedge clk);
    start = 1'b0; feat_en = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic dump(input string tag);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      host_ridx = 5'(i);
      #1;
      compared++;
      if (host_rdata !== mrf[i]) begin
        mismatched++;
        $display("FAIL %s reg %0d: actual %h expected %h", tag, i, host_rdata, mrf[i]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    dump("R12 reset");
    // R11: load every register while idle
    for (int i = 0; i < 32; i++)
      host_write(i, {$urandom, $urandom, $urandom, $urandom});
    // boundary operands, lanes 0..7 of reg 0 (first source) and reg 2 (second source)
    host_write(0, {16'hC040, 16'h8001, 16'h0080, 16'h3FC0, 16'h7F00, 16'h7F80, 16'h7F80, 16'h7F81});
    host_write(2, {16'h4000, 16'h3F80, 16'h3F00, 16'h3F81, 16'h7F00, 16'hBF80, 16'h0000, 16'h3F80});
    dump("R11 load");
    // R2 R3 R4 R5 R6: pair group, dst 16-17, srcs 0-1 and 2-3
    launch(1'b0, 4'd8, 4'd0, 4'd1, 1'b1);
    wait_idle();
    dump("R2 R3 R4 R5 R6 lanes");
    // R1 R2: quad group, dst 20-23, srcs 8-11 and 12-15
    launch(1'b1, 4'd5, 4'd2, 4'd3, 1'b1);
    wait_idle();
    dump("R1 R2 quad");
    // R7 R9 R11: quad dst overlapping first source, plus start and host write while busy
    launch(1'b1, 4'd2, 4'd2, 4'd3, 1'b1);
    @(negedge clk);
    start = 1'b1; grp4 = 1'b0; dst_sel = 4'd15; srca_sel = 4'd0; srcb_sel = 4'd0;
    host_we = 1'b1; host_widx = 5'd30; host_wdata = '1;
    @(negedge clk);
    start = 1'b0; host_we = 1'b0;
    wait_idle();
    dump("R7 R9 R11 overlap");
    // R7: pair dst identical to first source
    launch(1'b0, 4'd3, 4'd3, 4'd4, 1'b1);
    wait_idle();
    dump("R7 pair overlap");
    // R10: feature disabled
    launch(1'b1, 4'd0, 4'd1, 4'd2, 1'b0);
    wait_idle();
    dump("R10 refused");
    // R1: selector bit 3 ignored in quad mode (9 -> base 4, 14 -> base 24)
    launch(1'b1, 4'd14, 4'd9, 4'd10, 1'b1);
    wait_idle();
    dump("R1 high bit");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule